// File: doc/BRIEF.md
# Time-Slot Payload Sequencer

This block walks a frame of byte-interleaved columns one slot at a time and, for each slot, tells a datapath which of four lanes carry payload and to which output channel each payload byte belongs. The frame has twelve slots. Each slot has a programmable 16-bit entry made of four 4-bit codes, one code per lane. Lane i reads bits [4i+3:4i] of the entry.

A code whose upper two bits are `01` (values 0x4 to 0x7) marks the lane as valid payload, and its lower two bits give the channel (0 to 3). Every other value marks the lane invalid. That covers 0x0 to 0x3, the invalid markers for each lane, and 0x8 to 0xF, which are reserved. When only part of the frame is needed, for example three slots for each of four concatenated signals, the unused slots either repeat the valid pattern or hold invalid codes.

Configuration writes go into a staging copy. The sequencer moves the staging copy into the working copy only at a frame boundary, so a running frame never sees a partly updated table. One instance serves the transmit direction and an identical instance serves the receive direction.

Top module: `slot_sequencer`

## Requirements
- R1: After reset, `cur_slot` is 0 and `lane_valid` and `lane_chan` are all zero. The slot counter points at slot 1, and every entry, both staged and working, holds code 0x0 (invalid).
- R2: A cycle with `slot_adv` high presents the counter's slot. In the next cycle, `cur_slot` shows that slot number (1 to 12) and the lane outputs show the decoded working entry of that slot. The counter then moves to the following slot.
- R3: Presenting slot 12 returns the counter to slot 1, and the counter never holds a value outside 1 to 12.
- R4: `frame_start` forces the counter to slot 1, and it takes priority over the counter. With `slot_adv` high in the same cycle, slot 1 is presented and the counter moves to slot 2. Without `slot_adv`, nothing is presented and the counter waits at slot 1.
- R5: A code of 0x4, 0x5, 0x6 or 0x7 in lane i's field sets `lane_valid[i]` and drives channel 0, 1, 2 or 3 on `lane_chan[2i+1:2i]`.
- R6: Codes 0x0 to 0x3 and the reserved codes 0x8 to 0xF hold `lane_valid[i]` low and `lane_chan[2i+1:2i]` at 0.
- R7: A write on `cfg_we` to address a (0 to 11, slot a+1) reaches the working table only at the next frame boundary. A boundary is either the presentation of slot 12 or a `frame_start` cycle. A write in a `frame_start` cycle already applies to the slot 1 presented in that cycle. A write in the cycle that presents slot 12 applies from the following slot 1.
- R8: In a cycle after one without `slot_adv`, `lane_valid` is all zero and `cur_slot` keeps its value.
- R9: Writes to addresses 12 to 15 change no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Entry write enable |
| cfg_addr | input | 4 | Entry address; 0 to 11 select slots 1 to 12 |
| cfg_wdata | input | 16 | Entry value: four 4-bit lane codes |
| frame_start | input | 1 | Realign the counter to slot 1 and mark a frame boundary |
| slot_adv | input | 1 | Present the current slot, then advance |
| lane_valid | output | 4 | Per-lane payload-valid flag, one cycle after the strobe |
| lane_chan | output | 8 | Per-lane 2-bit channel index, 0 when the lane is invalid |
| cur_slot | output | 4 | Number of the slot last presented (1 to 12), 0 before the first one |

## Verification
The assertions assume that `slot_adv` and `frame_start` are synchronous single-cycle strobes. They also assume that nothing changes the working table except a frame boundary, which is why the table's stability is tied only to the strobe inputs and the counter. The bench drives every input on the falling edge through a single step task and keeps a model of the staged table, the working table and the counter built from the requirements. It also deliberately places writes in boundary cycles, in idle cycles and at out-of-range addresses, so that the deferred-update and ignored-write cases are seen at the lane outputs.

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
  parameter int NUM_SLOTS = 12,
  parameter int LANES     = 4,
  parameter int CODE_W    = 4,
  localparam int ENTRY_W  = LANES * CODE_W,
  localparam int ADDR_W   = $clog2(NUM_SLOTS),
  localparam int SLOT_W   = $clog2(NUM_SLOTS + 1),
  localparam int CHAN_W   = $clog2(LANES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [ENTRY_W-1:0]        cfg_wdata,
  input  logic                      frame_start,
  input  logic                      slot_adv,
  output logic [LANES-1:0]          lane_valid,
  output logic [LANES*CHAN_W-1:0]   lane_chan,
  output logic [SLOT_W-1:0]         cur_slot
);

  localparam int TABLE_W = ENTRY_W * NUM_SLOTS;
  localparam logic [SLOT_W-1:0] FIRST_SLOT = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(NUM_SLOTS);
  localparam logic [ADDR_W-1:0] LAST_ADDR  = ADDR_W'(NUM_SLOTS - 1);

  logic [TABLE_W-1:0] staged_q, staged_d, active_q;
  logic [SLOT_W-1:0]  cnt_q, cnt_d, sel;
  logic [ENTRY_W-1:0] cur_entry;
  logic [LANES-1:0]   valid_d;
  logic [LANES*CHAN_W-1:0] chan_d;
  logic               wrap, commit;

  always_comb begin
    staged_d = staged_q;
    if (cfg_we && cfg_addr <= LAST_ADDR)
      staged_d[int'(cfg_addr)*ENTRY_W +: ENTRY_W] = cfg_wdata;
  end

  assign sel    = frame_start ? FIRST_SLOT : cnt_q;
  assign wrap   = slot_adv && sel == LAST_SLOT;
  assign commit = frame_start || wrap;

  assign cur_entry = frame_start ? staged_d[(int'(sel)-1)*ENTRY_W +: ENTRY_W]
                                 : active_q[(int'(sel)-1)*ENTRY_W +: ENTRY_W];

  always_comb begin
    cnt_d = cnt_q;
    if (slot_adv)         cnt_d = wrap ? FIRST_SLOT : sel + FIRST_SLOT;
    else if (frame_start) cnt_d = FIRST_SLOT;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CODE_W-1:0] code;
    assign code = cur_entry[i*CODE_W +: CODE_W];
    assign valid_d[i] = (code >> CHAN_W) == CODE_W'(1);
    assign chan_d[i*CHAN_W +: CHAN_W] = valid_d[i] ? code[CHAN_W-1:0] : '0;

    AST_CHAN_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_valid[i] |-> lane_chan[i*CHAN_W +: CHAN_W] == '0); // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q   <= '0;
      active_q   <= '0;
      cnt_q      <= FIRST_SLOT;
      lane_valid <= '0;
      lane_chan  <= '0;
      cur_slot   <= '0;
    end else begin
      staged_q <= staged_d;
      if (commit) active_q <= staged_d;
      cnt_q <= cnt_d;
      lane_valid <= slot_adv ? valid_d : '0;
      lane_chan  <= slot_adv ? chan_d  : '0;
      if (slot_adv) cur_slot <= sel;
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q >= FIRST_SLOT && cnt_q <= LAST_SLOT); // R3

  AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_adv && !frame_start && cnt_q == LAST_SLOT) |=> (cnt_q == FIRST_SLOT && cur_slot == LAST_SLOT)); // R3

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_adv && !frame_start && cnt_q != LAST_SLOT) |=> (cur_slot == $past(cnt_q) && cnt_q == $past(cnt_q) + FIRST_SLOT)); // R2

  AST_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !slot_adv) |=> cnt_q == FIRST_SLOT); // R4

  AST_FRAME_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && slot_adv) |=> cur_slot == FIRST_SLOT); // R4

  AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_adv |=> (lane_valid == '0 && $stable(cur_slot))); // R8

  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !(slot_adv && cnt_q == LAST_SLOT)) |=> $stable(active_q)); // R7

endmodule

// File: tb/sim_slot_sequencer.sv
module sim_slot_sequencer;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic frame_start = 0;
  logic slot_adv = 0;
  logic [3:0] lane_valid;
  logic [7:0] lane_chan;
  logic [3:0] cur_slot;

  int checks = 0;
  int fails = 0;

  logic [15:0] m_act [12];
  logic [15:0] m_stg [12];
  int m_cnt;
  int m_cur;

  always #10 clk = ~clk;

  slot_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .slot_adv(slot_adv),
    .lane_valid(lane_valid), .lane_chan(lane_chan), .cur_slot(cur_slot)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void expect_entry(input logic [15:0] e, output logic [3:0] v, output logic [7:0] c);
    v = '0; c = '0;
    for (int i = 0; i < 4; i++) begin
      logic [3:0] code = e[i*4 +: 4];
      if (code >= 4'h4 && code <= 4'h7) begin
        v[i] = 1'b1;
        c[i*2 +: 2] = code[1:0];
      end
    end
  endfunction

  task automatic step(input bit we, input int addr, input logic [15:0] data,
                      input bit adv, input bit fs, input string req);
    logic [15:0] stg_new [12];
    logic [3:0] ev;
    logic [7:0] ec;
    int sel;
    stg_new = m_stg;
    if (we && addr < 12) stg_new[addr] = data;
    ev = '0; ec = '0;
    if (fs) m_act = stg_new;
    sel = fs ? 1 : m_cnt;
    if (adv) begin
      expect_entry(m_act[sel-1], ev, ec);
      m_cur = sel;
      if (sel == 12) m_act = stg_new;
      m_cnt = (sel == 12) ? 1 : sel + 1;
    end else if (fs) m_cnt = 1;
    m_stg = stg_new;
    @(negedge clk);
    cfg_we = we; cfg_addr = 4'(addr); cfg_wdata = data;
    slot_adv = adv; frame_start = fs;
    @(negedge clk);
    cfg_we = 0; slot_adv = 0; frame_start = 0;
    chk(req, "lane_valid", int'(lane_valid), int'(ev));
    chk(req, "lane_chan", int'(lane_chan), int'(ec));
    chk(req, "cur_slot", int'(cur_slot), m_cur);
  endtask

  task automatic run_frame(input string req);
    for (int s = 0; s < 12; s++) step(0, 0, 16'h0, 1, 0, req);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 12; i++) begin m_act[i] = '0; m_stg[i] = '0; end
    m_cnt = 1; m_cur = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "lane_valid", int'(lane_valid), 0);
    chk("R1", "lane_chan", int'(lane_chan), 0);
    chk("R1", "cur_slot", int'(cur_slot), 0);
    step(0, 0, 16'h0, 1, 0, "R1");
    chk("R1", "first slot", int'(cur_slot), 1);
    for (int s = 0; s < 11; s++) step(0, 0, 16'h0, 1, 0, "R1");
  endtask

  task automatic t_deferred_program;
    for (int a = 0; a < 12; a++) step(1, a, 16'h7654, 0, 0, "R7");
    run_frame("R7");
    run_frame("R2");
    chk("R3", "wrapped slot", int'(cur_slot), 12);
  endtask

  task automatic t_codes;
    step(1, 0, 16'h4567, 0, 0, "R5");
    step(1, 1, 16'h3210, 0, 0, "R6");
    step(1, 2, 16'h89AB, 0, 0, "R6");
    step(1, 3, 16'hCDEF, 0, 0, "R6");
    step(1, 4, 16'h8475, 0, 0, "R5");
    step(1, 5, 16'h0F06, 0, 0, "R6");
    step(0, 0, 16'h0, 1, 1, "R4");
    for (int s = 0; s < 11; s++) step(0, 0, 16'h0, 1, 0, "R5");
    chk("R3", "slot 12 reached", int'(cur_slot), 12);
    step(0, 0, 16'h0, 1, 0, "R3");
    chk("R3", "back to slot 1", int'(cur_slot), 1);
  endtask

  task automatic t_frame_realign;
    step(0, 0, 16'h0, 1, 0, "R2");
    step(0, 0, 16'h0, 1, 0, "R2");
    step(0, 0, 16'h0, 0, 1, "R4");
    step(0, 0, 16'h0, 1, 0, "R4");
    chk("R4", "slot after realign", int'(cur_slot), 1);
    step(0, 0, 16'h0, 1, 0, "R4");
    step(0, 0, 16'h0, 1, 1, "R4");
    step(0, 0, 16'h0, 1, 0, "R4");
    chk("R4", "slot after start+adv", int'(cur_slot), 2);
  endtask

  task automatic t_same_cycle_write;
    step(1, 0, 16'h5555, 1, 1, "R7");
    chk("R7", "slot1 new value", int'(lane_valid), 4'hF);
    for (int s = 0; s < 10; s++) step(0, 0, 16'h0, 1, 0, "R7");
    step(1, 0, 16'h0000, 1, 0, "R7");
    step(0, 0, 16'h0, 1, 0, "R7");
    chk("R7", "slot1 after wrap write", int'(lane_valid), 0);
  endtask

  task automatic t_bad_addr;
    for (int a = 12; a < 16; a++) step(1, a, 16'h4444, 0, 0, "R9");
    step(0, 0, 16'h0, 1, 1, "R9");
    for (int s = 0; s < 11; s++) step(0, 0, 16'h0, 1, 0, "R9");
    run_frame("R9");
  endtask

  task automatic t_idle;
    step(0, 0, 16'h0, 1, 0, "R8");
    step(0, 0, 16'h0, 0, 0, "R8");
    step(1, 2, 16'h6666, 0, 0, "R8");
    step(0, 0, 16'h0, 0, 0, "R8");
    step(0, 0, 16'h0, 1, 0, "R8");
  endtask

  initial begin
    t_reset;
    t_deferred_program;
    t_codes;
    t_frame_realign;
    t_same_cycle_write;
    t_bad_addr;
    t_idle;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule